// File: doc/BRIEF.md
# Glitch-Free Clock Stop and Power-Down Gate

This block sits after the clock synthesizer and in front of the output drivers. It produces three groups of clock outputs from one fast reference: a processor group, a memory group that runs at the same rate and phase as the processor group, and a slower bus group. Each output is a flop, so its waveform is formed from whole reference cycles. A group's gate and its per-output enables may change only on the reference edge that starts a new cycle of that group's clock. As a result, every pulse it emits has full width.

Two asynchronous, active-low requests control the gating. Each passes through a two-flop synchronizer. The processor-stop request parks only the processor group low. The power-down request parks every group low and raises a status flag once all gates are closed. When power-down is released, a wake timer counts a set number of processor cycles before any output starts again. This timer stands in for the relock time of an upstream PLL. An output whose enable bit is 0 is driven low; it is never left floating.

Top module: `clkstop_gate`

## Requirements
- R1: While reset is active, and after reset for as long as both request inputs are low, every clock output is 0 and `parked_o` is 1.
- R2: Every high pulse on a processor or memory output lasts exactly CPU_HALF reference cycles, and every high pulse on a bus output lasts exactly CPU_HALF*BUS_MULT reference cycles. Every low gap between two pulses is at least as long as a high pulse. This holds for any timing of requests and enable changes. With defaults, in 40 reference cycles of free running, a processor output rises 10 times and a bus output rises 5 times.
- R3: The memory outputs rise on the same reference edge as the processor outputs, which is the edge that starts a processor cycle. Every rising edge of a bus output coincides with the start of a processor cycle.
- R4: After `stop_ni` falls, a processor output emits at most one more rising edge and is low from 3 processor periods (12 reference cycles with defaults) after the request. Memory and bus outputs keep running.
- R5: After `stop_ni` rises, the first processor rising edge appears on one of the first 6 reference edges, and it starts a full-width pulse.
- R6: After `pwr_dwn_ni` falls, all outputs are low, and `parked_o` is 1, by 20 reference cycles. No output rises after that. While `parked_o` is 1, every output is 0.
- R7: After `pwr_dwn_ni` rises, `parked_o` drops. The first processor rising edge falls on reference edge k, counted from the release, where WAKE_CYC*2*CPU_HALF <= k <= WAKE_CYC*2*CPU_HALF + 2*CPU_HALF - 1 (24 to 27 with defaults).
- R8: If `stop_ni` is low when power-down ends, the memory output restarts within the R7 window while the processor outputs stay low. The processor outputs restart as R5 describes once `stop_ni` rises.
- R9: An output whose enable bit is 0 (bit i of `cpu_en_i`, `mem_en_i` or `bus_en_i` gates bit i of the matching output) stays low, and the other outputs are unaffected. Setting the bit back to 1 restores the output at full rate.
- R10: If power-down is requested again before the wake timer expires, no output pulses, and the block returns to the parked state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock from which all outputs are formed |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stop_ni | input | 1 | Asynchronous processor-stop request, active low |
| pwr_dwn_ni | input | 1 | Asynchronous power-down request, active low |
| cpu_en_i | input | N_CPU | Per-output enables, processor group |
| mem_en_i | input | N_MEM | Per-output enables, memory group |
| bus_en_i | input | N_BUS | Per-output enables, bus group |
| cpu_clk_o | output | N_CPU | Gated processor clocks |
| mem_clk_o | output | N_MEM | Gated memory clocks, in phase with the processor clocks |
| bus_clk_o | output | N_BUS | Gated bus clocks |
| parked_o | output | 1 | High while powered down with every gate closed |

## Verification
Some properties can be checked on every cycle, and the assertions cover them. Each high pulse must have exact width. Processor and memory edges must share one phase, and bus edges must line up with processor cycle starts. All outputs must be quiet while the parked flag is high. The request latencies need scenarios in the bench: the stop and restart windows, the power-down wake delay, stop held through the wake, and power-down re-asserted during the wake. The bench sweeps the arrival of each request over every reference phase of a bus period and applies a walking-zero enable over every output. It counts rising edges and measures the sample at which each rising edge first appears.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;

    // Power sequencing states of the gate
    typedef enum logic [1:0] {
        PD_RUN  = 2'd0,
        PD_HOLD = 2'd1,
        PD_WAKE = 2'd2
    } pd_state_e;

endpackage

// File: rtl/clkstop_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer for a vector of independent asynchronous levels.
// Reset value is 0, i.e. an active-low request reads as asserted until
// the pin has been sampled twice.
module clkstop_sync #(
    parameter int W = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] safe;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.meta = async_i;
        s_d.safe = s_q.meta;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign sync_o = s_q.safe;
endmodule

// File: rtl/clkstop_phase.sv
`timescale 1ns/1ps
// Phase counters: position inside a processor period and processor
// periods inside a bus period. Start and level flags describe the value
// the counters take on the coming edge, so registered outputs line up.
module clkstop_phase #(
    parameter  int CPU_HALF = 2,
    parameter  int BUS_MULT = 2,
    localparam int P        = 2 * CPU_HALF,
    localparam int CW       = (P > 1) ? $clog2(P) : 1,
    localparam int BW       = (BUS_MULT > 1) ? $clog2(BUS_MULT) : 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    output logic          cpu_start_o,
    output logic          bus_start_o,
    output logic          cpu_hi_o,
    output logic          bus_hi_o,
    output logic [CW-1:0] cpu_ph_o,
    output logic [BW-1:0] bus_ph_o
);
    localparam int BHI = BUS_MULT * CPU_HALF;

    typedef struct packed {
        logic [CW-1:0] cpu;
        logic [BW-1:0] bus;
    } ph_t;

    ph_t ph_d, ph_q;
    logic        wrap;
    logic [31:0] bus_pos;

    always_comb begin
        wrap     = (ph_q.cpu == CW'(P - 1));
        ph_d     = ph_q;
        ph_d.cpu = wrap ? '0 : ph_q.cpu + 1'b1;
        if (wrap) begin
            ph_d.bus = (ph_q.bus == BW'(BUS_MULT - 1)) ? '0 : ph_q.bus + 1'b1;
        end
        bus_pos     = 32'(ph_d.bus) * 32'(P) + 32'(ph_d.cpu);
        cpu_start_o = (ph_d.cpu == '0);
        bus_start_o = cpu_start_o && (ph_d.bus == '0);
        cpu_hi_o    = (ph_d.cpu < CW'(CPU_HALF));
        bus_hi_o    = (bus_pos < 32'(BHI));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ph_q.cpu <= CW'(P - 1);
            ph_q.bus <= BW'(BUS_MULT - 1);
        end else begin
            ph_q <= ph_d;
        end
    end

    assign cpu_ph_o = ph_q.cpu;
    assign bus_ph_o = ph_q.bus;
endmodule

// File: rtl/clkstop_group.sv
`timescale 1ns/1ps
// One output group. Gate and enables are captured only on the edge that
// begins a new cycle of the group, so every pulse is whole.
module clkstop_group #(
    parameter int N = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         start_i,
    input  logic         allow_i,
    input  logic         hi_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] clk_o,
    output logic         gate_o
);
    typedef struct packed {
        logic         gate;
        logic [N-1:0] en;
        logic [N-1:0] ck;
    } grp_t;

    grp_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (start_i) begin
            g_d.gate = allow_i;
            g_d.en   = en_i;
        end
        g_d.ck = {N{g_d.gate & hi_i}} & g_d.en;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) g_q <= '0;
        else         g_q <= g_d;
    end

    // Outputs drive low while disabled: one flop per pin
    for (genvar i = 0; i < N; i++) begin : g_pin
        assign clk_o[i] = g_q.ck[i];
    end
    assign gate_o = g_q.gate;
endmodule

// File: rtl/clkstop_pd_fsm.sv
`timescale 1ns/1ps
// Power-down sequencer with wake timer counted in processor periods.
module clkstop_pd_fsm
    import clkstop_pkg::*;
#(
    parameter  int WAKE_CYC = 6,
    localparam int TW       = $clog2(WAKE_CYC + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pd_req_i,
    input  logic cpu_start_i,
    input  logic gates_idle_i,
    output logic run_o,
    output logic parked_o
);
    typedef struct packed {
        pd_state_e     st;
        logic [TW-1:0] tmr;
        logic          parked;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        unique case (f_q.st)
            PD_RUN: begin
                if (pd_req_i) f_d.st = PD_HOLD;
            end
            PD_HOLD: begin
                if (!pd_req_i) begin
                    f_d.st  = PD_WAKE;
                    f_d.tmr = TW'(WAKE_CYC);
                end
            end
            PD_WAKE: begin
                if (pd_req_i) begin
                    f_d.st = PD_HOLD;
                end else if (cpu_start_i) begin
                    if (f_q.tmr <= TW'(1)) f_d.st  = PD_RUN;
                    else                   f_d.tmr = f_q.tmr - 1'b1;
                end
            end
            default: f_d.st = PD_HOLD;
        endcase
        f_d.parked = (f_q.st == PD_HOLD) && gates_idle_i;
        run_o      = (f_d.st == PD_RUN);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            f_q.st     <= PD_HOLD;
            f_q.tmr    <= '0;
            f_q.parked <= 1'b1;
        end else begin
            f_q <= f_d;
        end
    end

    assign parked_o = f_q.parked;
endmodule

// File: rtl/clkstop_gate.sv
`timescale 1ns/1ps
// Top: synchronizers, phase counters, sequencer and three output groups.
module clkstop_gate #(
    parameter  int N_CPU    = 4,
    parameter  int N_MEM    = 12,
    parameter  int N_BUS    = 7,
    parameter  int CPU_HALF = 2,
    parameter  int BUS_MULT = 2,
    parameter  int WAKE_CYC = 6,
    localparam int P        = 2 * CPU_HALF,
    localparam int CW       = (P > 1) ? $clog2(P) : 1,
    localparam int BW       = (BUS_MULT > 1) ? $clog2(BUS_MULT) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             stop_ni,
    input  logic             pwr_dwn_ni,
    input  logic [N_CPU-1:0] cpu_en_i,
    input  logic [N_MEM-1:0] mem_en_i,
    input  logic [N_BUS-1:0] bus_en_i,
    output logic [N_CPU-1:0] cpu_clk_o,
    output logic [N_MEM-1:0] mem_clk_o,
    output logic [N_BUS-1:0] bus_clk_o,
    output logic             parked_o
);
    logic [1:0]    req_s;
    logic          cpu_start, bus_start, cpu_hi, bus_hi;
    logic [CW-1:0] cpu_ph_q;
    logic [BW-1:0] bus_ph_q;
    logic          run, cpu_gate, mem_gate, bus_gate;

    // bit 1: power-down pin, bit 0: processor-stop pin (1 = run)
    clkstop_sync #(.W(2)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i({pwr_dwn_ni, stop_ni}),
        .sync_o (req_s)
    );

    clkstop_phase #(.CPU_HALF(CPU_HALF), .BUS_MULT(BUS_MULT)) u_phase (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cpu_start_o(cpu_start),
        .bus_start_o(bus_start),
        .cpu_hi_o   (cpu_hi),
        .bus_hi_o   (bus_hi),
        .cpu_ph_o   (cpu_ph_q),
        .bus_ph_o   (bus_ph_q)
    );

    clkstop_pd_fsm #(.WAKE_CYC(WAKE_CYC)) u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .pd_req_i    (!req_s[1]),
        .cpu_start_i (cpu_start),
        .gates_idle_i(!(cpu_gate | mem_gate | bus_gate)),
        .run_o       (run),
        .parked_o    (parked_o)
    );

    clkstop_group #(.N(N_CPU)) u_cpu (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .start_i(cpu_start),
        .allow_i(run & req_s[0]),
        .hi_i   (cpu_hi),
        .en_i   (cpu_en_i),
        .clk_o  (cpu_clk_o),
        .gate_o (cpu_gate)
    );

    clkstop_group #(.N(N_MEM)) u_mem (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .start_i(cpu_start),
        .allow_i(run),
        .hi_i   (cpu_hi),
        .en_i   (mem_en_i),
        .clk_o  (mem_clk_o),
        .gate_o (mem_gate)
    );

    clkstop_group #(.N(N_BUS)) u_bus (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .start_i(bus_start),
        .allow_i(run),
        .hi_i   (bus_hi),
        .en_i   (bus_en_i),
        .clk_o  (bus_clk_o),
        .gate_o (bus_gate)
    );
endmodule

// File: rtl/clkstop_gate_chk.sv
`timescale 1ns/1ps
// Cycle-level checks on the gated outputs, attached by bind.
module clkstop_gate_chk #(
    parameter  int N_CPU    = 4,
    parameter  int N_MEM    = 12,
    parameter  int N_BUS    = 7,
    parameter  int CPU_HALF = 2,
    parameter  int BUS_MULT = 2,
    localparam int P        = 2 * CPU_HALF,
    localparam int CW       = (P > 1) ? $clog2(P) : 1,
    localparam int BW       = (BUS_MULT > 1) ? $clog2(BUS_MULT) : 1
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [N_CPU-1:0] cpu_clk_o,
    input logic [N_MEM-1:0] mem_clk_o,
    input logic [N_BUS-1:0] bus_clk_o,
    input logic             parked_o,
    input logic [CW-1:0]    cpu_ph,
    input logic [BW-1:0]    bus_ph
);
    logic [7:0] cpu_run_q, bus_run_q;

    // Length of the current high run, saturating
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cpu_run_q <= '0;
            bus_run_q <= '0;
        end else begin
            cpu_run_q <= cpu_clk_o[0] ? ((cpu_run_q == 8'hFF) ? cpu_run_q : cpu_run_q + 1'b1) : '0;
            bus_run_q <= bus_clk_o[0] ? ((bus_run_q == 8'hFF) ? bus_run_q : bus_run_q + 1'b1) : '0;
        end
    end

    assert_cpu_full_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(cpu_clk_o[0]) |-> (cpu_run_q == 8'(CPU_HALF)));

    assert_bus_full_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(bus_clk_o[0]) |-> (bus_run_q == 8'(CPU_HALF * BUS_MULT)));

    assert_mem_in_phase_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mem_clk_o[0]) |-> (cpu_ph == '0));

    assert_bus_on_cpu_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(bus_clk_o[0]) |-> (cpu_ph == '0 && bus_ph == '0));

    assert_cpu_on_boundary_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cpu_clk_o[0]) |-> (cpu_ph == '0));

    assert_parked_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        parked_o |-> (cpu_clk_o == '0 && mem_clk_o == '0 && bus_clk_o == '0));
endmodule

bind clkstop_gate clkstop_gate_chk #(
    .N_CPU   (N_CPU),
    .N_MEM   (N_MEM),
    .N_BUS   (N_BUS),
    .CPU_HALF(CPU_HALF),
    .BUS_MULT(BUS_MULT)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cpu_clk_o(cpu_clk_o),
    .mem_clk_o(mem_clk_o),
    .bus_clk_o(bus_clk_o),
    .parked_o (parked_o),
    .cpu_ph   (cpu_ph_q),
    .bus_ph   (bus_ph_q)
);

// File: tb/tb_clkstop_gate.sv
`timescale 1ns/1ps
module tb_clkstop_gate;
    localparam int NC = 4, NM = 12, NB = 7, NT = NC + NM + NB;
    localparam int HALF = 2, MULT = 2, WAKE = 6;
    localparam int P = 2 * HALF;
    localparam int WLO = WAKE * P, WHI = WAKE * P + P - 1;
    localparam int MB = NC;          // first memory bit in the flat vector
    localparam int BB = NC + NM;     // first bus bit in the flat vector

    logic clk = 1'b0;
    logic rst_n, stop_n, pwr_n, parked;
    logic [NC-1:0] cpu_en, cpu_clk;
    logic [NM-1:0] mem_en, mem_clk;
    logic [NB-1:0] bus_en, bus_clk;

    int checks = 0, errs = 0;
    int rises [NT];
    logic [NT-1:0] prev = '0;
    int hi_len [NT];
    int lo_len [NT];
    bit done = 0;

    always #2.5 clk = ~clk;

    clkstop_gate #(.N_CPU(NC), .N_MEM(NM), .N_BUS(NB), .CPU_HALF(HALF),
                   .BUS_MULT(MULT), .WAKE_CYC(WAKE)) dut (
        .clk_i(clk), .rst_ni(rst_n), .stop_ni(stop_n), .pwr_dwn_ni(pwr_n),
        .cpu_en_i(cpu_en), .mem_en_i(mem_en), .bus_en_i(bus_en),
        .cpu_clk_o(cpu_clk), .mem_clk_o(mem_clk), .bus_clk_o(bus_clk),
        .parked_o(parked));

    function automatic logic [NT-1:0] outs();
        return {bus_clk, mem_clk, cpu_clk};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        logic [NT-1:0] cur;
        @(negedge clk);
        cur = outs();
        for (int i = 0; i < NT; i++) if (cur[i] && !prev[i]) rises[i]++;
        prev = cur;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic clr();
        for (int i = 0; i < NT; i++) rises[i] = 0;
    endtask

    task automatic first_rise(input int b, input int n, output int k);
        k = 0;
        for (int i = 1; i <= n; i++) begin
            step();
            if (outs()[b] && k == 0) k = i;
        end
    endtask

    // Pulse-width monitor for every output (R2, R9)
    initial for (int i = 0; i < NT; i++) begin hi_len[i] = 0; lo_len[i] = 1000; end
    always @(negedge clk) begin
        logic [NT-1:0] c;
        int w;
        c = outs();
        if (rst_n) begin
            for (int i = 0; i < NT; i++) begin
                w = (i < BB) ? HALF : HALF * MULT;
                if (c[i]) begin
                    if (hi_len[i] == 0) begin
                        checks++;
                        if (lo_len[i] < w) begin
                            errs++;
                            $display("FAIL R2 gap bit %0d: actual %0d expected >= %0d", i, lo_len[i], w);
                        end
                        lo_len[i] = 0;
                    end
                    hi_len[i]++;
                end else begin
                    if (hi_len[i] > 0) begin
                        checks++;
                        if (hi_len[i] != w) begin
                            errs++;
                            $display("FAIL R2 pulse bit %0d: actual %0d expected %0d", i, hi_len[i], w);
                        end
                    end
                    hi_len[i] = 0;
                    lo_len[i]++;
                end
            end
        end
    end

    initial begin
        fork
            begin : main_seq
                int k, bad, refb, expn;
                logic [NT-1:0] pv, cv;
                logic [NT-1:0] en;
                rst_n = 0; stop_n = 0; pwr_n = 0;
                cpu_en = '1; mem_en = '1; bus_en = '1;
                clr();
                steps(3);
                chk(outs() == '0, "R1 outputs in reset", int'(outs() != '0), 0);
                chk(parked == 1'b1, "R1 parked in reset", int'(parked), 1);
                #1 rst_n = 1;
                steps(6);
                chk(outs() == '0, "R1 outputs, pins low", int'(outs() != '0), 0);
                chk(parked == 1'b1, "R1 parked, pins low", int'(parked), 1);

                #1 pwr_n = 1; stop_n = 1;
                first_rise(0, 40, k);
                chk(k >= WLO && k <= WHI, "R7 first wake edge", k, WLO);
                chk(parked == 1'b0, "R7 parked drops", int'(parked), 0);

                // Free-running rate and phase
                steps(8); clr(); bad = 0;
                for (int i = 0; i < 40; i++) begin
                    pv = prev; step(); cv = prev;
                    if (cv[MB] != cv[0]) bad++;
                    if (cv[BB] && !pv[BB] && !(cv[0] && !pv[0])) bad++;
                end
                chk(rises[0] == 10, "R2 cpu rate", rises[0], 10);
                chk(rises[MB] == 10, "R2 mem rate", rises[MB], 10);
                chk(rises[BB] == 5, "R2 bus rate", rises[BB], 5);
                chk(bad == 0, "R3 phase alignment", bad, 0);

                // Stop and restart at every reference phase of a bus period
                for (int off = 0; off < 2 * P; off++) begin
                    steps(off);
                    #1 stop_n = 0;
                    clr(); steps(12);
                    chk(rises[0] <= 1, "R4 edges after stop", rises[0], 1);
                    clr(); steps(16);
                    chk(rises[0] == 0, "R4 cpu parked", rises[0], 0);
                    chk(rises[MB] == 4, "R4 mem unaffected", rises[MB], 4);
                    chk(rises[BB] == 2, "R4 bus unaffected", rises[BB], 2);
                    #1 stop_n = 1;
                    first_rise(0, 12, k);
                    chk(k >= 1 && k <= 6, "R5 restart latency", k, 6);
                    steps(8);
                end

                // Walking-zero enable over every output
                for (int b = 0; b < NT; b++) begin
                    en = '1; en[b] = 1'b0;
                    #1 {bus_en, mem_en, cpu_en} = en;
                    steps(12); clr(); steps(16);
                    chk(rises[b] == 0, "R9 disabled output low", rises[b], 0);
                    refb = (b == 0) ? 1 : 0;
                    chk(rises[refb] == 4, "R9 neighbour unaffected", rises[refb], 4);
                    #1 {bus_en, mem_en, cpu_en} = '1;
                    steps(12); clr(); steps(16);
                    expn = (b < BB) ? 4 : 2;
                    chk(rises[b] == expn, "R9 re-enabled output", rises[b], expn);
                end

                // Power-down at every phase; odd offsets keep stop low at release
                for (int off = 0; off < 2 * P; off++) begin
                    steps(off);
                    #1 pwr_n = 0;
                    clr(); steps(10); clr(); steps(10);
                    bad = 0;
                    for (int i = 0; i < NT; i++) bad += rises[i];
                    chk(bad == 0, "R6 no edges when parked", bad, 0);
                    chk(outs() == '0, "R6 outputs low", int'(outs() != '0), 0);
                    chk(parked == 1'b1, "R6 parked flag", int'(parked), 1);
                    if (off % 2 == 0) begin
                        #1 pwr_n = 1;
                        first_rise(0, 40, k);
                        chk(k >= WLO && k <= WHI, "R7 wake latency", k, WLO);
                    end else begin
                        #1 pwr_n = 1; stop_n = 0;
                        clr();
                        first_rise(MB, 40, k);
                        chk(k >= WLO && k <= WHI, "R8 mem wakes", k, WLO);
                        chk(rises[0] == 0, "R8 cpu held by stop", rises[0], 0);
                        #1 stop_n = 1;
                        first_rise(0, 12, k);
                        chk(k >= 1 && k <= 6, "R8 cpu restart", k, 6);
                    end
                    steps(8);
                end

                // Power-down re-asserted during the wake wait
                #1 pwr_n = 0;
                steps(20);
                #1 pwr_n = 1;
                clr(); steps(10);
                #1 pwr_n = 0;
                steps(40);
                bad = 0;
                for (int i = 0; i < NT; i++) bad += rises[i];
                chk(bad == 0, "R10 no pulse on aborted wake", bad, 0);
                chk(parked == 1'b1, "R10 parked again", int'(parked), 1);
                #1 pwr_n = 1;
                first_rise(0, 40, k);
                chk(k >= WLO && k <= WHI, "R10 later wake", k, WLO);
                steps(10);
                done = 1;
            end
            begin : watchdog
                repeat (200000) @(posedge clk);
            end
        join_any
        disable fork;
        if (!done) begin
            checks++; errs++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end
endmodule